// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Time Insertion

This block drives a pair of complementary outputs, PWM and PWMN, from one fast clock. It is meant for a half-bridge or a pulser stage. A fixed period of `2*HALF_SCALE` clock cycles is split into a high phase, whose length is the duty input, and a low phase. A programmable dead time of whole clock cycles is placed at the start of each phase. In that gap both outputs are low, so the switch that turns off always completes before the other one turns on. At a clock of a few hundred megahertz, one dead-time step is a few nanoseconds.

An external sequencer drives the enable input to gate bursts of pulses. While the block is disabled it rests in a safe state: PWM low and PWMN high. When enable drops, the current period always runs to its end before the block returns to rest, so a burst is always made of whole periods and the dead time is never broken. The duty and dead-time settings are captured only when a period starts.

Top module: `cpwm_deadband`

## Requirements
- R1: While the synchronous active-low reset is asserted, and after it is released, PWM is low and PWMN is high until enable is first sampled high.
- R2: While the block is idle (enable low and no period in progress), PWM stays low and PWMN stays high, whatever the duty and dead-time inputs do.
- R3: PWM and PWMN are never both high in the same cycle.
- R4: A period is `2*HALF_SCALE` cycles long (62 by default), with positions 0 to 61. With duty D and dead time T captured for that period, PWM is high exactly at positions c where T <= c < D. That is max(0, D-T) cycles per period.
- R5: PWMN is high exactly at positions c where D+T <= c < 62. That is max(0, 62-D-T) cycles per period.
- R6: When D > T and D+T < 62, both outputs are low for exactly T cycles after PWM falls and before PWMN rises. Both are also low for exactly T cycles after PWMN falls and before PWM rises.
- R7: A duty of 31 (0x1F) with dead time 0 gives PWM high for 31 of every 62 cycles, which is 50 %. The full-scale duty is 62.
- R8: If enable is dropped during a period, that period completes unchanged, including a PWM pulse already under way. Only after position 61 do the outputs return to PWM low, PWMN high.
- R9: Changes on the duty or dead-time inputs in the middle of a period do not alter that period. They apply from the next period.
- R10: If T >= D, PWM does not pulse at all. A duty above 62 is treated as 62, which gives PWM high at positions T through 61 and no PWMN pulse.
- R11: When enable is sampled high at clock edge k while the block is idle, position 0 of the first period appears on the outputs after edge k+1. Edge k itself leaves the idle levels in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all timing counts these cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Burst gate; a high level starts or continues periods |
| duty_i | input | $clog2(2*HALF_SCALE+1) | High-phase length in cycles, captured at period start |
| dead_i | input | DT_W | Dead time in cycles, captured at period start |
| pwm_o | output | 1 | Main output, low when idle |
| pwmn_o | output | 1 | Complementary output, high when idle |

## Verification
The bench targets the edges where a plausible bug shows up. It drops enable while PWM is high; a design that stops at once would cut the pulse short and make both outputs switch together. It changes the duty in the middle of a period; a design that does not capture its settings would stretch the running pulse. It measures the low-low gap on both transitions; an off-by-one in the compare would give T-1 or T+1 cycles. It uses a dead time larger than the duty and a duty above full scale; a design without the clamp would emit short glitches or wrap its counter. A cycle-by-cycle reference built from the position rules checks every output sample throughout the run.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // Run state shared by the period sequencer and the output shaper
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } run_e;

    // Clamp a requested duty into the legal range 0..limit
    function automatic int unsigned clamp_duty(input int unsigned req, input int unsigned limit);
        return (req > limit) ? limit : req;
    endfunction

endpackage

// File: rtl/cpwm_period.sv
module cpwm_period
    import cpwm_pkg::*;
#(
    parameter int HALF_SCALE = 31,
    parameter int DT_W       = 5,
    localparam int PERIOD    = 2 * HALF_SCALE,
    localparam int CNT_W     = $clog2(PERIOD),
    localparam int DUTY_W    = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DT_W-1:0]   dead_i,
    output run_e              run_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [DUTY_W-1:0] duty_o,
    output logic [DT_W-1:0]   dead_o
);

    localparam logic [CNT_W-1:0]  LAST_POS  = CNT_W'(PERIOD - 1);
    localparam logic [DUTY_W-1:0] FULL_DUTY = DUTY_W'(PERIOD);

    typedef struct packed {
        run_e              run;
        logic [CNT_W-1:0]  cnt;
        logic [DUTY_W-1:0] duty;
        logic [DT_W-1:0]   dead;
    } per_state_t;

    per_state_t st_d, st_q;
    logic [DUTY_W-1:0] duty_clamped;

    always_comb begin
        duty_clamped = DUTY_W'(clamp_duty(int'(duty_i), int'(FULL_DUTY)));
        st_d = st_q;
        if (st_q.run == PH_IDLE) begin
            if (en_i) begin
                st_d.run  = PH_RUN;
                st_d.cnt  = '0;
                st_d.duty = duty_clamped;
                st_d.dead = dead_i;
            end
        end else if (st_q.cnt == LAST_POS) begin
            // period boundary: continue with fresh settings or fall idle
            if (en_i) begin
                st_d.cnt  = '0;
                st_d.duty = duty_clamped;
                st_d.dead = dead_i;
            end else begin
                st_d.run = PH_IDLE;
                st_d.cnt = '0;
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.run  <= PH_IDLE;
            st_q.cnt  <= '0;
            st_q.duty <= '0;
            st_q.dead <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o  = st_q.run;
    assign cnt_o  = st_q.cnt;
    assign duty_o = st_q.duty;
    assign dead_o = st_q.dead;

    AST_RUN_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o == PH_RUN && cnt_o != LAST_POS) |=> (run_o == PH_RUN)); // R8
    AST_HOLD_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o == PH_RUN && cnt_o != LAST_POS) |=> ($stable(duty_o) && $stable(dead_o))); // R9
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o == PH_RUN && cnt_o == LAST_POS && en_i) |=> (run_o == PH_RUN && cnt_o == '0)); // R4
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o == PH_IDLE && en_i) |=> (run_o == PH_RUN && cnt_o == '0)); // R11
    AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o == PH_RUN) |-> (duty_o <= FULL_DUTY)); // R10

endmodule

// File: rtl/cpwm_shaper.sv
module cpwm_shaper
    import cpwm_pkg::*;
#(
    parameter int HALF_SCALE = 31,
    parameter int DT_W       = 5,
    localparam int PERIOD    = 2 * HALF_SCALE,
    localparam int CNT_W     = $clog2(PERIOD),
    localparam int DUTY_W    = $clog2(PERIOD + 1),
    localparam int SUM_W     = ((DUTY_W > DT_W) ? DUTY_W : DT_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  run_e              run_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DT_W-1:0]   dead_i,
    output logic              pwm_o,
    output logic              pwmn_o
);

    typedef struct packed {
        logic pwm;
        logic pwmn;
    } out_state_t;

    out_state_t out_d, out_q;
    logic [SUM_W-1:0] pos_w, duty_w, dead_w, low_start_w;

    always_comb begin
        pos_w       = SUM_W'(cnt_i);
        duty_w      = SUM_W'(duty_i);
        dead_w      = SUM_W'(dead_i);
        low_start_w = duty_w + dead_w;
        if (run_i == PH_RUN) begin
            // high phase opens after the dead gap; an empty window means no pulse
            out_d.pwm  = (pos_w >= dead_w) && (pos_w < duty_w);
            out_d.pwmn = (pos_w >= low_start_w);
        end else begin
            out_d.pwm  = 1'b0;
            out_d.pwmn = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.pwm  <= 1'b0;
            out_q.pwmn <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign pwm_o  = out_q.pwm;
    assign pwmn_o = out_q.pwmn;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_o && pwmn_o)); // R3
    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i == PH_IDLE) |=> (!pwm_o && pwmn_o)); // R2
    AST_NO_PULSE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i == PH_RUN && dead_i >= DT_W'(0) && SUM_W'(dead_i) >= SUM_W'(duty_i)) |=> !pwm_o); // R10

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
    import cpwm_pkg::*;
#(
    parameter int HALF_SCALE = 31,
    parameter int DT_W       = 5,
    localparam int PERIOD    = 2 * HALF_SCALE,
    localparam int CNT_W     = $clog2(PERIOD),
    localparam int DUTY_W    = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DT_W-1:0]   dead_i,
    output logic              pwm_o,
    output logic              pwmn_o
);

    run_e              run_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [DUTY_W-1:0] duty_w;
    logic [DT_W-1:0]   dead_w;

    cpwm_period #(
        .HALF_SCALE(HALF_SCALE),
        .DT_W      (DT_W)
    ) u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .duty_i(duty_i),
        .dead_i(dead_i),
        .run_o (run_w),
        .cnt_o (cnt_w),
        .duty_o(duty_w),
        .dead_o(dead_w)
    );

    cpwm_shaper #(
        .HALF_SCALE(HALF_SCALE),
        .DT_W      (DT_W)
    ) u_shaper (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run_w),
        .cnt_i (cnt_w),
        .duty_i(duty_w),
        .dead_i(dead_w),
        .pwm_o (pwm_o),
        .pwmn_o(pwmn_o)
    );

    AST_RESET_LEVELS: assert property (@(posedge clk)
        !rst_n |=> (!pwm_o && pwmn_o)); // R1

endmodule

// File: tb/tb_cpwm_deadband.sv
module tb_cpwm_deadband;

    localparam int CLK_PERIOD = 4;
    localparam int P          = 62;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [5:0] duty_i = '0;
    logic [4:0] dead_i = '0;
    logic       pwm_o, pwmn_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cpwm_deadband dut (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .duty_i(duty_i),
        .dead_i(dead_i),
        .pwm_o (pwm_o),
        .pwmn_o(pwmn_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference built from the position rules of R4/R5/R8/R9/R11
    int m_run, m_cnt, m_d, m_t;
    int e_pwm, e_pwmn;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run <= 0; m_cnt <= 0; m_d <= 0; m_t <= 0;
            e_pwm <= 0; e_pwmn <= 1;
        end else begin
            e_pwm  <= (m_run != 0 && m_cnt >= m_t && m_cnt < m_d) ? 1 : 0;
            e_pwmn <= (m_run == 0 || m_cnt >= m_d + m_t) ? 1 : 0;
            if (m_run == 0) begin
                if (en_i) begin
                    m_run <= 1; m_cnt <= 0;
                    m_d <= (int'(duty_i) > P) ? P : int'(duty_i);
                    m_t <= int'(dead_i);
                end
            end else if (m_cnt == P - 1) begin
                m_cnt <= 0;
                if (en_i) begin
                    m_d <= (int'(duty_i) > P) ? P : int'(duty_i);
                    m_t <= int'(dead_i);
                end else begin
                    m_run <= 0;
                end
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 reference pwm", int'(pwm_o), e_pwm);
            chk("R5 reference pwmn", int'(pwmn_o), e_pwmn);
            chk("R3 no overlap", int'(pwm_o && pwmn_o), 0);
        end
    end

    task automatic go_idle();
        @(negedge clk);
        en_i = 1'b0;
        repeat (P + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 pwm in reset", int'(pwm_o), 0);
        chk("R1 pwmn in reset", int'(pwmn_o), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pwm after reset", int'(pwm_o), 0);
        chk("R1 pwmn after reset", int'(pwmn_o), 1);
    endtask

    task automatic t_idle();
        int bad = 0;
        for (int i = 0; i < 40; i++) begin
            duty_i = 6'(i); dead_i = 5'(i % 7);
            @(negedge clk);
            if (pwm_o || !pwmn_o) bad++;
        end
        chk("R2 idle levels held", bad, 0);
    endtask

    task automatic t_start();
        int hi = 0, lo = 0;
        go_idle();
        duty_i = 6'd31; dead_i = 5'd2; en_i = 1'b1;
        @(negedge clk);
        chk("R11 idle after sampling edge", int'(pwmn_o), 1);
        @(negedge clk);
        chk("R11 pwmn low at position 0", int'(pwmn_o), 0);
        chk("R11 pwm low at position 0", int'(pwm_o), 0);
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
            if (pwmn_o) lo++;
        end
        chk("R4 pwm high count D31 T2", hi, 29);
        chk("R5 pwmn high count D31 T2", lo, 29);
    endtask

    task automatic t_half();
        int hi = 0;
        go_idle();
        duty_i = 6'h1F; dead_i = 5'd0; en_i = 1'b1;
        repeat (5) @(negedge clk);
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
        end
        chk("R7 half duty count", hi, 31);
    endtask

    task automatic t_dead();
        int gap;
        int prev;
        go_idle();
        duty_i = 6'd20; dead_i = 5'd3; en_i = 1'b1;
        prev = 0;
        @(negedge clk);
        while (!(prev == 1 && pwm_o == 1'b0)) begin
            prev = int'(pwm_o);
            @(negedge clk);
        end
        gap = 1;
        @(negedge clk);
        while (!pwm_o && !pwmn_o) begin gap++; @(negedge clk); end
        chk("R6 gap pwm fall to pwmn rise", gap, 3);
        while (pwmn_o) @(negedge clk);
        gap = 1;
        @(negedge clk);
        while (!pwm_o && !pwmn_o) begin gap++; @(negedge clk); end
        chk("R6 gap pwmn fall to pwm rise", gap, 3);
    endtask

    task automatic t_stop();
        int hi;
        go_idle();
        duty_i = 6'd40; dead_i = 5'd2; en_i = 1'b1;
        while (!pwm_o) @(negedge clk);
        en_i = 1'b0;
        hi = 1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
        end
        chk("R8 pulse completes after enable drop", hi, 38);
        chk("R8 pwm idle after stop", int'(pwm_o), 0);
        chk("R8 pwmn idle after stop", int'(pwmn_o), 1);
    endtask

    task automatic t_midchange();
        int w;
        go_idle();
        duty_i = 6'd20; dead_i = 5'd2; en_i = 1'b1;
        while (!pwm_o) @(negedge clk);
        duty_i = 6'd40; dead_i = 5'd5;
        w = 0;
        while (pwm_o) begin w++; @(negedge clk); end
        chk("R9 running pulse keeps old setting", w, 18);
        while (!pwm_o) @(negedge clk);
        w = 0;
        while (pwm_o) begin w++; @(negedge clk); end
        chk("R9 next pulse uses new setting", w, 35);
    endtask

    task automatic t_clamp();
        int hi = 0, lo = 0;
        go_idle();
        duty_i = 6'd8; dead_i = 5'd10; en_i = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 2 * P; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
            if (pwmn_o) lo++;
        end
        chk("R10 no pwm pulse when T>=D", hi, 0);
        chk("R5 pwmn count when T>=D", lo, 2 * 44);
        go_idle();
        hi = 0; lo = 0;
        duty_i = 6'd63; dead_i = 5'd0; en_i = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 2 * P; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
            if (pwmn_o) lo++;
        end
        chk("R10 duty above full scale pwm", hi, 2 * P);
        chk("R10 duty above full scale pwmn", lo, 0);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_up();
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_start();
        t_half();
        t_dead();
        t_stop();
        t_midchange();
        t_clamp();
        go_idle();
        finish_up();
    end

endmodule